// File: doc/BRIEF.md
# Single-Wire Bus ROM Command Layer

This block is the addressing layer of a slave on a multi-drop single-wire bus. After every reset/presence exchange it takes one command byte from the host and then either reports its 64-bit identity, compares a host-supplied identity against its own, selects itself outright, or joins the bus-wide search. When the command completes successfully it raises `selected`. That flag hands the bus to the memory command layer.

The block does not time the wire. A separate slot engine tells it when each time slot has completed and what bit the host left on the wire. The layer tells the engine whether the next slot is one in which the slave drives a bit, and which bit. The identity is fixed at elaboration. It is built from a family code, a serial number and a check byte. The check byte is supplied as a parameter and is not computed here.

Identity bit order: bit index 0 is the least significant bit of the family code. Indices 0 to 7 are the family code, 8 to 55 the serial number, and 56 to 63 the check byte. Within each byte the bits go out least significant first.

Top module: `sw_rom_layer`

## Requirements
- R1: After `rst_n` is released, `selected` and `tx_en` are 0, and all completed slots are ignored until the first `bus_reset` pulse.
- R2: A `bus_reset` pulse clears `selected` and `tx_en` in the following cycle. It also returns the layer to collecting a command byte, and it takes priority over a slot completing in the same cycle.
- R3: The command byte is taken from 8 host-write slots (`tx_en` = 0), least significant bit first. The codes are 33h read, 55h match, CCh skip and F0h search.
- R4: After 33h the next 64 slots are slave-driven (`tx_en` = 1). Slot n carries identity bit n, and `selected` rises after the 64th slot.
- R5: After 55h the next 64 slots are host writes. If every received bit equals the identity bit of the same index, `selected` rises after the 64th slot.
- R6: If any bit received after 55h differs from the identity, `selected` and `tx_en` stay 0 and every further slot is ignored until `bus_reset`.
- R7: After CCh, `selected` rises immediately after the 8th command slot, with no identity exchange.
- R8: After F0h each identity bit n uses three slots. The first sends bit n and the second sends its complement, both with `tx_en` = 1. The third is a host write with `tx_en` = 0.
- R9: In the search, if the bit in a third slot differs from identity bit n, the slave drops out. `tx_en` and `selected` then stay 0 until `bus_reset`.
- R10: A slave still in the search after the third slot of bit 63 raises `selected`.
- R11: Any command code other than the four in R3 leaves `selected` and `tx_en` at 0 until `bus_reset`.
- R12: Once raised, `selected` holds through further slots until `bus_reset`. `tx_en` and `tx_bit` change only after a completed slot or a `bus_reset`.
- R13: The family code defaults to 09h. It is the first identity byte sent by the read command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_reset | input | 1 | One-cycle pulse: host reset pulse seen on the wire |
| slot_valid | input | 1 | One-cycle pulse: a time slot has completed |
| slot_rx | input | 1 | Bit sampled on the wire in the completed slot |
| tx_en | output | 1 | Next slot is slave-driven |
| tx_bit | output | 1 | Bit the slave drives in the next slot (1 when not driving) |
| selected | output | 1 | Device addressed; memory layer may proceed |

## Verification
The assertions hold on every cycle for several properties. A bus reset clears both outputs. `selected` and `tx_en` are never high together. `selected` rises only on a completed slot and holds until reset. The outputs stay still between slots. Whether the right identity bit and complement appear in each slot can only be shown by the bench's scenarios. The same holds for whether a mismatch at a given bit index really silences the slave, and for whether unknown codes leave it idle. The bench sweeps the mismatch position over all 64 indices for both match and search, and it sweeps all 256 command codes.

// File: rtl/sw_rom_layer_pkg.sv
package sw_rom_layer_pkg;

    localparam int CMD_W = 8;

    localparam logic [CMD_W-1:0] CODE_READ   = 8'h33;
    localparam logic [CMD_W-1:0] CODE_MATCH  = 8'h55;
    localparam logic [CMD_W-1:0] CODE_SKIP   = 8'hCC;
    localparam logic [CMD_W-1:0] CODE_SEARCH = 8'hF0;

    typedef enum logic [2:0] {
        ST_MUTE,
        ST_CMD,
        ST_READ,
        ST_MATCH,
        ST_S_BIT,
        ST_S_CMP,
        ST_S_HOST,
        ST_SEL
    } rl_state_e;

    typedef enum logic [2:0] {
        OP_READ,
        OP_MATCH,
        OP_SKIP,
        OP_SEARCH,
        OP_BAD
    } rom_op_e;

endpackage

// File: rtl/rom_op_decode.sv
module rom_op_decode
    import sw_rom_layer_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output rom_op_e          op
);
    always_comb begin
        case (code)
            CODE_READ:   op = OP_READ;
            CODE_MATCH:  op = OP_MATCH;
            CODE_SKIP:   op = OP_SKIP;
            CODE_SEARCH: op = OP_SEARCH;
            default:     op = OP_BAD;
        endcase
    end
endmodule

// File: rtl/rom_id_pick.sv
module rom_id_pick #(
    parameter int ID_W  = 64,
    parameter int IDX_W = $clog2(ID_W)
) (
    input  logic [ID_W-1:0]  ident,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    assign bit_o = ident[idx];
endmodule

// File: rtl/sw_rom_layer.sv
module sw_rom_layer
    import sw_rom_layer_pkg::*;
#(
    parameter int               FAM_W  = 8,
    parameter int               SER_W  = 48,
    parameter int               CHK_W  = 8,
    parameter logic [FAM_W-1:0] FAMILY = 8'h09,
    parameter logic [SER_W-1:0] SERIAL = 48'h0000_1234_5678,
    parameter logic [CHK_W-1:0] ID_CHK = 8'h00
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic slot_valid,
    input  logic slot_rx,
    output logic tx_en,
    output logic tx_bit,
    output logic selected
);
    localparam int ID_W  = FAM_W + SER_W + CHK_W;
    localparam int IDX_W = $clog2(ID_W);
    localparam logic [ID_W-1:0]  IDENT    = {ID_CHK, SERIAL, FAMILY};
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);
    localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);

    typedef struct packed {
        rl_state_e        state;
        logic [IDX_W-1:0] idx;
        logic [CMD_W-1:0] cmd;
    } rl_regs_t;

    rl_regs_t cur_q, nxt_d;

    logic             id_bit;
    logic [CMD_W-1:0] cmd_full;
    rom_op_e          op;
    logic             at_last;

    rom_id_pick #(.ID_W(ID_W), .IDX_W(IDX_W)) u_pick (
        .ident (IDENT),
        .idx   (cur_q.idx),
        .bit_o (id_bit)
    );

    assign cmd_full = {slot_rx, cur_q.cmd[CMD_W-1:1]};

    rom_op_decode u_dec (
        .code (cmd_full),
        .op   (op)
    );

    assign at_last = (cur_q.idx == IDX_LAST);

    always_comb begin
        nxt_d = cur_q;
        if (bus_reset) begin
            nxt_d.state = ST_CMD;
            nxt_d.idx   = '0;
            nxt_d.cmd   = '0;
        end else if (slot_valid) begin
            case (cur_q.state)
                ST_CMD: begin
                    nxt_d.cmd = cmd_full;
                    if (cur_q.idx == CMD_LAST) begin
                        nxt_d.idx = '0;
                        case (op)
                            OP_READ:   nxt_d.state = ST_READ;
                            OP_MATCH:  nxt_d.state = ST_MATCH;
                            OP_SKIP:   nxt_d.state = ST_SEL;
                            OP_SEARCH: nxt_d.state = ST_S_BIT;
                            default:   nxt_d.state = ST_MUTE;
                        endcase
                    end else begin
                        nxt_d.idx = cur_q.idx + 1'b1;
                    end
                end
                ST_READ: begin
                    if (at_last) nxt_d.state = ST_SEL;
                    else         nxt_d.idx   = cur_q.idx + 1'b1;
                end
                ST_MATCH: begin
                    if (slot_rx != id_bit) nxt_d.state = ST_MUTE;
                    else if (at_last)      nxt_d.state = ST_SEL;
                    else                   nxt_d.idx   = cur_q.idx + 1'b1;
                end
                ST_S_BIT: nxt_d.state = ST_S_CMP;
                ST_S_CMP: nxt_d.state = ST_S_HOST;
                ST_S_HOST: begin
                    if (slot_rx != id_bit) begin
                        nxt_d.state = ST_MUTE;
                    end else if (at_last) begin
                        nxt_d.state = ST_SEL;
                    end else begin
                        nxt_d.idx   = cur_q.idx + 1'b1;
                        nxt_d.state = ST_S_BIT;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= ST_MUTE;
            cur_q.idx   <= '0;
            cur_q.cmd   <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        tx_en  = (cur_q.state == ST_READ) || (cur_q.state == ST_S_BIT)
              || (cur_q.state == ST_S_CMP);
        tx_bit = 1'b1;
        if (tx_en) tx_bit = (cur_q.state == ST_S_CMP) ? ~id_bit : id_bit;
        selected = (cur_q.state == ST_SEL);
    end

endmodule

// File: rtl/sw_rom_layer_chk.sv
module sw_rom_layer_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_reset,
    input logic slot_valid,
    input logic tx_en,
    input logic tx_bit,
    input logic selected
);
    assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!selected && !tx_en));

    assert_sel_not_driving_R12: assert property (@(posedge clk) disable iff (!rst_n)
        selected |-> !tx_en);

    assert_sel_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (selected && !bus_reset) |=> selected);

    assert_sel_needs_slot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> ($past(slot_valid) && !$past(bus_reset)));

    assert_quiet_between_slots_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_valid && !bus_reset) |=> ($stable(tx_en) && $stable(tx_bit)));
endmodule

bind sw_rom_layer sw_rom_layer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .slot_valid (slot_valid),
    .tx_en      (tx_en),
    .tx_bit     (tx_bit),
    .selected   (selected)
);

// File: tb/sim_sw_rom_layer.sv
module sim_sw_rom_layer;
    localparam logic [47:0] TB_SER = 48'h5A3C_0F96_E1B4;
    localparam logic [7:0]  TB_CHK = 8'hC7;
    localparam logic [63:0] TB_ID  = {TB_CHK, TB_SER, 8'h09};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 1'b0;
    logic slot_valid = 1'b0;
    logic slot_rx = 1'b1;
    logic tx_en, tx_bit, selected;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    sw_rom_layer #(.SERIAL(TB_SER), .ID_CHK(TB_CHK)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .slot_valid(slot_valid),
        .slot_rx(slot_rx), .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic slot(input logic rx);
        @(negedge clk);
        slot_valid = 1'b1;
        slot_rx    = rx;
        @(negedge clk);
        slot_valid = 1'b0;
        slot_rx    = 1'b1;
    endtask

    task automatic bus_rst();
        @(negedge clk);
        bus_reset = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0;
    endtask

    task automatic send_cmd(input logic [7:0] c);
        for (int b = 0; b < 8; b++) slot(c[b]);
    endtask

    task automatic idle_ok(input string tag);
        check(!selected && !tx_en, tag, {selected, tx_en}, 64'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        idle_ok("R1 reset state");
        send_cmd(8'hCC);
        idle_ok("R1 slots ignored before bus reset");

        // skip, hold, reset
        bus_rst();
        idle_ok("R2 after bus reset");
        send_cmd(8'hCC);
        check(selected, "R7 skip selects", selected, 1);
        send_cmd(8'h33);
        check(selected && !tx_en, "R12 selected holds", {selected, tx_en}, 64'h2);
        @(negedge clk);
        bus_reset = 1'b1; slot_valid = 1'b1;
        @(negedge clk);
        bus_reset = 1'b0; slot_valid = 1'b0;
        idle_ok("R2 reset clears selected, wins over slot");
        send_cmd(8'hCC);
        check(selected, "R2 R3 command collected after reset", selected, 1);

        // read
        begin
            logic [63:0] got = '0;
            bit ok = 1'b1;
            bus_rst();
            send_cmd(8'h33);
            for (int i = 0; i < 64; i++) begin
                if (!tx_en) ok = 1'b0;
                got[i] = tx_bit;
                slot(1'b1);
            end
            check(ok, "R4 read slots slave driven", ok, 1);
            check(got == TB_ID, "R4 read identity order", got, TB_ID);
            check(got[7:0] == 8'h09, "R13 family code first", got[7:0], 8'h09);
            check(selected, "R4 read then selected", selected, 1);
        end

        // match full
        bus_rst();
        send_cmd(8'h55);
        for (int i = 0; i < 64; i++) slot(TB_ID[i]);
        check(selected, "R5 match selects", selected, 1);

        // match mismatch sweep
        for (int k = 0; k < 64; k++) begin
            bit ok = 1'b1;
            bus_rst();
            send_cmd(8'h55);
            for (int i = 0; i < 64; i++) begin
                slot(i == k ? ~TB_ID[i] : TB_ID[i]);
                if (selected || tx_en) ok = 1'b0;
            end
            send_cmd(8'hCC);
            if (selected || tx_en) ok = 1'b0;
            check(ok, $sformatf("R6 match miss at %0d", k), ok, 1);
        end

        // search full
        begin
            bit okb = 1'b1;
            bit okc = 1'b1;
            bus_rst();
            send_cmd(8'hF0);
            for (int i = 0; i < 64; i++) begin
                if (!tx_en || tx_bit != TB_ID[i]) okb = 1'b0;
                slot(1'b1);
                if (!tx_en || tx_bit != ~TB_ID[i]) okc = 1'b0;
                slot(1'b1);
                if (tx_en) okb = 1'b0;
                slot(TB_ID[i]);
            end
            check(okb, "R8 search bit and host slots", okb, 1);
            check(okc, "R8 search complement slots", okc, 1);
            check(selected, "R10 search survivor selected", selected, 1);
        end

        // search drop-out sweep
        for (int k = 0; k < 64; k++) begin
            bit ok = 1'b1;
            bus_rst();
            send_cmd(8'hF0);
            for (int i = 0; i < 64; i++) begin
                if (i > k && tx_en) ok = 1'b0;
                slot(1'b1);
                slot(1'b1);
                slot(i == k ? ~TB_ID[i] : TB_ID[i]);
                if (i >= k && (tx_en || selected)) ok = 1'b0;
            end
            check(ok, $sformatf("R9 search drop at %0d", k), ok, 1);
        end

        // unknown codes
        for (int c = 0; c < 256; c++) begin
            if (c == 8'h33 || c == 8'h55 || c == 8'hCC || c == 8'hF0) continue;
            begin
                bit ok = 1'b1;
                bus_rst();
                send_cmd(8'(c));
                if (selected || tx_en) ok = 1'b0;
                send_cmd(8'hCC);
                if (selected || tx_en) ok = 1'b0;
                check(ok, $sformatf("R11 unknown code %02h", c), ok, 1);
            end
        end

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule